// File: doc/BRIEF.md
# Trigger-Delayed Circular Capture Buffer

This block sits in a digital acquisition path and keeps a rolling history of incoming samples. Once armed, every accepted sample goes into the next slot of a circular memory of depth N, so the newest N samples are always held. A trigger qualified by a valid sample does not stop writing at once. It starts a countdown, and the memory freezes only after the programmed number of further samples has been written. The delay therefore decides where the trigger falls in the frozen window: at the very end (delay 0), in the middle (delay N/2), or just before the window starts (delay N).

After the freeze the block raises a done flag. It reports how many entries hold data and the record index at which post-trigger samples begin. The record can then be read back in time order, with logical address 0 being the oldest stored sample. A rearm pulse discards the record and starts a new capture.

Top module: `trig_capture_buf`

## Requirements
- R1: After reset, done, rd_vld and fill_cnt are 0, and samples or triggers presented before arming change nothing.
- R2: arm is accepted only when the block is idle. It clears the stored count, sets the write position to 0 and latches dly_set. An arm pulse while done has no effect.
- R3: While capturing, each cycle with smp_vld high writes one sample. fill_cnt counts the writes and saturates at N, after which the oldest entry is overwritten.
- R4: A trigger counts only when trig and smp_vld are high together while waiting; that sample is the trigger sample. A trig without smp_vld, a trig while idle, and any later trig before rearm are ignored.
- R5: With a latched delay of 0, capture freezes on the trigger sample itself, and post_start equals fill_cnt.
- R6: With a latched delay d, exactly d further valid samples are written after the trigger sample. done rises on the edge that writes the d-th one, and later samples are not stored.
- R7: A dly_set value above N is latched as N, giving post_start 0 with a full record.
- R8: Changes to dly_set after arm or rearm have no effect on the running capture.
- R9: When done, rd_en with logical index rd_addr returns the sample at that position counted from the oldest stored sample, with rd_vld and rd_data one cycle later. rd_en while not done produces no rd_vld.
- R10: rearm is accepted only when done. It clears done and fill_cnt, latches dly_set and resumes writing from write position 0. rearm while idle is ignored.
- R11: If capture freezes before N samples have been written, fill_cnt gives the number of valid entries, and logical index 0 is the first sample written after arming.
- R12: post_start equals fill_cnt minus the latched delay, which is the record index of the first post-trigger sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start a capture from idle |
| rearm | input | 1 | Start a new capture after done |
| dly_set | input | AW+1 | Post-trigger sample count, clamped to N |
| smp_data | input | DW | Sample value |
| smp_vld | input | 1 | Sample strobe |
| trig | input | 1 | Trigger mark for the sample in the same cycle |
| done | output | 1 | Record frozen |
| fill_cnt | output | AW+1 | Number of valid entries in the record |
| post_start | output | AW+1 | Record index of first post-trigger sample |
| rd_en | input | 1 | Read request |
| rd_addr | input | AW | Logical read index, 0 = oldest |
| rd_data | output | DW | Read sample |
| rd_vld | output | 1 | rd_data valid |

## Verification
A write pointer that is off by one shows up at once on readback: every sample in the record moves by one position, so the first compare after done fails. A wrong delay count or a wrong freeze condition shows up as done rising one sample early or late. It also shows up as a fill_cnt or post_start that does not match, and as a record whose last entry is the wrong sample. Any state that lets triggers or samples through when they should be ignored moves the freeze point, which the bench notices within a few samples of the stray event.

// File: rtl/trig_capture_buf.sv
module trig_capture_buf #(
  parameter int DW = 12,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          rearm,
  input  logic [AW:0]   dly_set,
  input  logic [DW-1:0] smp_data,
  input  logic          smp_vld,
  input  logic          trig,
  output logic          done,
  output logic [AW:0]   fill_cnt,
  output logic [AW:0]   post_start,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_vld
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] NFULL = (AW+1)'(DEPTH);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_POST, ST_DONE} st_t;
  st_t st;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp;
  logic [AW:0]   fill, dly_q, rem;

  wire          take   = smp_vld && (st == ST_WAIT || st == ST_POST);
  wire          hit    = smp_vld && trig && st == ST_WAIT;
  wire          start  = (st == ST_IDLE && arm) || (st == ST_DONE && rearm);
  wire [AW:0]   dly_in = (dly_set > NFULL) ? NFULL : dly_set;
  wire [AW-1:0] oldest = (fill == NFULL) ? wp : '0;
  wire [AW-1:0] rp     = oldest + rd_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; wp <= '0; fill <= '0; dly_q <= '0; rem <= '0;
    end else begin
      if (start) begin
        st <= ST_WAIT; wp <= '0; fill <= '0; dly_q <= dly_in;
      end
      if (take) begin
        wp <= wp + 1'b1;
        if (fill != NFULL) fill <= fill + 1'b1;
      end
      if (hit) begin
        st  <= (dly_q == '0) ? ST_DONE : ST_POST;
        rem <= dly_q;
      end
      if (st == ST_POST && smp_vld) begin
        rem <= rem - 1'b1;
        if (rem == 1) st <= ST_DONE;
      end
    end
  end

  always_ff @(posedge clk)
    if (take) mem[wp] <= smp_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_vld  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_vld <= rd_en && done;
      if (rd_en && done) rd_data <= mem[rp];
    end
  end

  assign done       = (st == ST_DONE);
  assign fill_cnt   = fill;
  assign post_start = fill - dly_q;

  assert_fill_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= NFULL);
  assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rearm) |=> (done && $stable(fill_cnt) && $stable(wp)));
  assert_freeze_on_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(smp_vld));
  assert_rd_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && done) |=> rd_vld);
  assert_no_rd_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> !rd_vld);
  assert_rearm_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rearm) |=> (!done && fill_cnt == '0));
  assert_arm_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && arm && !rearm) |=> done);
  assert_post_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> post_start <= fill_cnt);
endmodule

// File: tb/sim_trig_capture_buf.sv
module sim_trig_capture_buf;
  localparam int DW = 12;
  localparam int AW = 4;
  localparam int N  = 1 << AW;

  logic clk = 0, rst_n = 0, arm = 0, rearm = 0, smp_vld = 0, trig = 0, rd_en = 0;
  logic [AW:0] dly_set = '0;
  logic [DW-1:0] smp_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic done, rd_vld;
  logic [AW:0] fill_cnt, post_start;
  logic [DW-1:0] rd_data;

  int checks = 0, fails = 0;
  logic [DW-1:0] log_q[$];
  logic [DW-1:0] exp_q[$];
  bit m_run = 0, m_post = 0, m_done = 0;
  int m_dly = 0, m_rem = 0;

  always #2 clk = ~clk;

  trig_capture_buf #(.DW(DW), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .arm(arm), .rearm(rearm), .dly_set(dly_set),
    .smp_data(smp_data), .smp_vld(smp_vld), .trig(trig), .done(done),
    .fill_cnt(fill_cnt), .post_start(post_start), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_vld(rd_vld));

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int m_fill();
    return (log_q.size() > N) ? N : log_q.size();
  endfunction

  always @(negedge clk) begin
    if (rst_n && rd_vld) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R9 actual=rd_vld expected=no read pending");
      end else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        if (rd_data !== e) begin
          fails++;
          $display("FAIL R9 actual=%0d expected=%0d", rd_data, e);
        end
      end
    end
  end

  task automatic send(input logic [DW-1:0] d, input bit t);
    @(negedge clk);
    chk("R6 done", done, m_done);
    chk("R3 fill", fill_cnt, m_fill());
    smp_data = d; smp_vld = 1; trig = t;
    if (m_run && !m_done) begin
      log_q.push_back(d);
      if (m_post) begin
        m_rem--;
        if (m_rem == 0) m_done = 1;
      end else if (t) begin
        if (m_dly == 0) m_done = 1;
        else begin m_post = 1; m_rem = m_dly; end
      end
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); smp_vld = 0; trig = 0; arm = 0; rearm = 0; rd_en = 0;
    end
  endtask

  task automatic start_cap(bit use_rearm, int d, bit accepted);
    @(negedge clk);
    smp_vld = 0; trig = 0;
    dly_set = (AW+1)'(d);
    if (use_rearm) rearm = 1; else arm = 1;
    @(negedge clk); arm = 0; rearm = 0;
    if (accepted) begin
      m_run = 1; m_post = 0; m_done = 0; m_dly = (d > N) ? N : d;
      log_q.delete();
    end
  endtask

  task automatic read_all(string req);
    int k = m_fill();
    int base = log_q.size() - k;
    chk({req, " done"}, done, 1);
    chk({req, " fill"}, fill_cnt, k);
    chk("R12 post_start", post_start, k - m_dly);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      exp_q.push_back(log_q[base + i]);
      rd_en = 1; rd_addr = AW'(i);
    end
    @(negedge clk); rd_en = 0;
    idle(3);
    chk("R9 all reads returned", exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 done", done, 0);
    chk("R1 fill", fill_cnt, 0);
    chk("R1 rd_vld", rd_vld, 0);
    // R1/R4: samples and triggers while idle are ignored; R10: rearm while idle ignored
    for (int i = 0; i < 5; i++) send(12'h010 + 12'(i), i == 2);
    start_cap(1, 3, 0);
    for (int i = 0; i < 3; i++) send(12'h020 + 12'(i), 1'b1);
    idle(2);
    chk("R1 fill after idle samples", fill_cnt, 0);
    chk("R10 rearm idle ignored", done, 0);

    // R6: delay N/2, second trigger ignored (R4)
    start_cap(0, N/2, 1);
    for (int i = 0; i < 30; i++) send(12'h100 + 12'(i), i == 20 || i == 22);
    idle(2);
    chk("R6 trigger sample at N-1-d", post_start, N - N/2);
    read_all("R6");

    // R5: delay 0; R8: dly_set change ignored; R4: trig without valid ignored
    start_cap(1, 0, 1);
    dly_set = 5;
    @(negedge clk); trig = 1; smp_vld = 0;
    @(negedge clk); trig = 0;
    for (int i = 0; i < 20; i++) send(12'h200 + 12'(i), i == 18);
    idle(2);
    chk("R5 post_start equals fill", post_start, fill_cnt);
    read_all("R5");

    // R2: arm while done ignored
    @(negedge clk); arm = 1;
    @(negedge clk); arm = 0;
    idle(2);
    chk("R2 arm in done", done, 1);
    chk("R2 fill kept", fill_cnt, N);

    // R7: delay above N clamped
    start_cap(1, N + 4, 1);
    for (int i = 0; i < 40; i++) send(12'h300 + 12'(i), i == 5);
    idle(2);
    chk("R7 post_start zero", post_start, 0);
    read_all("R7");

    // R11: partial fill; R9: reads while not done give nothing
    start_cap(1, 2, 1);
    @(negedge clk); rd_en = 1; rd_addr = 0;
    @(negedge clk); rd_en = 0;
    @(negedge clk);
    chk("R9 no rd_vld when not done", rd_vld, 0);
    for (int i = 0; i < 6; i++) send(12'h400 + 12'(i), i == 2);
    idle(2);
    chk("R11 partial fill", fill_cnt, 5);
    read_all("R11");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule